// File: doc/BRIEF.md
# Posted Store Queue with Drain Barrier

This block sits between a processor's store port and a slow memory port. A bufferable store is accepted in a single cycle, parked in a short in-order queue, and the processor moves on at once. The queue hands its oldest entry to memory over a valid/ready handshake. Each entry retires when that handshake completes, so memory may take as long as it needs.

The processor can set up two kinds of ordering. A drain request makes the block hold the processor stalled until every store queued so far has been accepted by memory. A store marked non-bufferable is never parked. The block first waits for the queue to empty and then drives that store straight onto the memory port. It keeps the processor stalled until memory takes it, so the store has reached memory before the processor carries on.

Top module: `store_queue`

## Requirements
- R1: After a synchronous reset the queue is empty, `cpu_stall` is low and `mem_valid` is low.
- R2: A bufferable store is taken in any cycle where `cpu_valid` is high and `cpu_stall` is low. If the queue was empty, it appears on the memory port in the next cycle with its address, data and size. The size codes are 00 byte, 01 halfword and 10 word.
- R3: Entries retire to memory strictly in arrival order, one for each cycle in which `mem_valid` and `mem_ready` are both high. While `mem_valid` is high and `mem_ready` is low, address, data and size hold steady.
- R4: With DEPTH (default 4) entries queued, `cpu_stall` is high and no store is taken until an entry retires.
- R5: A drain request is taken in a cycle with `cpu_stall` low. From the next cycle `cpu_stall` stays high until every entry queued at that point has retired, including a store taken in the same cycle. It drops in the cycle after the last of those handshakes.
- R6: A drain request that finds the queue empty, or whose only remaining entry retires in the same cycle, causes no stall.
- R7: A non-bufferable store raises `cpu_stall` from the next cycle. It reaches the memory port only after every earlier queued store has retired. `cpu_stall` stays high until its own handshake and drops in the following cycle.
- R8: Reset in the middle of operation discards all queued entries and any pending drain or non-bufferable store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Store request from the processor |
| cpu_bufferable | input | 1 | 1: store may be queued; 0: store must complete before the processor continues |
| cpu_addr | input | 32 | Store address |
| cpu_data | input | 32 | Store data |
| cpu_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| cpu_drain | input | 1 | Drain request (barrier) |
| cpu_stall | output | 1 | Processor must hold its request and wait |
| mem_valid | output | 1 | A store is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered store |
| mem_addr | output | 32 | Offered store address |
| mem_data | output | 32 | Offered store data |
| mem_size | output | 2 | Offered store size |

## Verification
Two functions can fall in the same cycle: a drain request being taken and a queue entry retiring. The bench sets both up on one edge. It raises `cpu_drain` in the same cycle as `mem_ready` while a single entry is queued, and judges that `cpu_stall` never rises. It then pairs a drain with a new bufferable store on one edge and judges that the stall lasts exactly until that store's handshake.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } xfer_size_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        xfer_size_e        size;
    } store_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DRAIN,
        ST_UB_WAIT,
        ST_UB_SEND
    } ctl_state_e;

    // advance a ring index, wrapping at depth
    function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  store_t wr,
    input  logic   pop,
    output store_t rd,
    output logic   empty,
    output logic   full,
    output logic   empty_next
);

    store_t          slot_q [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [CW-1:0]   fill;
    logic [CW-1:0]   fill_n;

    assign fill_n     = fill + CW'(push) - CW'(pop);
    assign empty      = (fill == '0);
    assign full       = (fill == CW'(DEPTH));
    assign empty_next = (fill_n == '0);
    assign rd         = slot_q[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wr_ptr] <= wr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            fill <= fill_n;
            if (push) begin
                wr_ptr <= PW'(ring_next(int'(wr_ptr), DEPTH));
            end
            if (pop) begin
                rd_ptr <= PW'(ring_next(int'(rd_ptr), DEPTH));
            end
        end
    end

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
    import wbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_valid,
    input  logic cpu_bufferable,
    input  logic cpu_drain,
    input  logic q_full,
    input  logic q_empty_next,
    input  logic mem_ready,
    output logic cpu_stall,
    output logic q_push,
    output logic ub_load,
    output logic ub_send
);

    ctl_state_e state_q;
    ctl_state_e state_n;
    logic       take;
    logic       drain_take;

    assign cpu_stall  = (state_q != ST_RUN) || q_full;
    assign take       = cpu_valid && !cpu_stall;
    assign q_push     = take && cpu_bufferable;
    assign ub_load    = take && !cpu_bufferable;
    assign drain_take = cpu_drain && !cpu_stall;
    assign ub_send    = (state_q == ST_UB_SEND);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ub_load) begin
                    state_n = q_empty_next ? ST_UB_SEND : ST_UB_WAIT;
                end else if (drain_take && !q_empty_next) begin
                    state_n = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (q_empty_next) state_n = ST_RUN;
            end
            ST_UB_WAIT: begin
                if (q_empty_next) state_n = ST_UB_SEND;
            end
            ST_UB_SEND: begin
                if (mem_ready) state_n = ST_RUN;
            end
            default: state_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_n;
    end

endmodule

// File: rtl/store_queue.sv
module store_queue
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_bufferable,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [1:0]        cpu_size,
    input  logic              cpu_drain,
    output logic              cpu_stall,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [1:0]        mem_size
);

    store_t in_st;
    store_t head;
    store_t ub_q;
    store_t out_st;
    logic   q_push;
    logic   q_pop;
    logic   q_empty;
    logic   q_full;
    logic   q_empty_next;
    logic   ub_load;
    logic   ub_send;

    assign in_st.addr = cpu_addr;
    assign in_st.data = cpu_data;
    assign in_st.size = xfer_size_e'(cpu_size);

    // queue head goes out only when no direct store owns the port
    assign q_pop = !ub_send && !q_empty && mem_ready;

    wbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (q_push),
        .wr         (in_st),
        .pop        (q_pop),
        .rd         (head),
        .empty      (q_empty),
        .full       (q_full),
        .empty_next (q_empty_next)
    );

    wbuf_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .cpu_valid      (cpu_valid),
        .cpu_bufferable (cpu_bufferable),
        .cpu_drain      (cpu_drain),
        .q_full         (q_full),
        .q_empty_next   (q_empty_next),
        .mem_ready      (mem_ready),
        .cpu_stall      (cpu_stall),
        .q_push         (q_push),
        .ub_load        (ub_load),
        .ub_send        (ub_send)
    );

    always_ff @(posedge clk) begin
        if (rst)          ub_q <= '0;
        else if (ub_load) ub_q <= in_st;
    end

    assign out_st    = ub_send ? ub_q : head;
    assign mem_valid = ub_send || !q_empty;
    assign mem_addr  = out_st.addr;
    assign mem_data  = out_st.data;
    assign mem_size  = out_st.size;

endmodule

// File: rtl/store_queue_chk.sv
module store_queue_chk
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic              cpu_bufferable,
    input logic              cpu_drain,
    input logic              cpu_stall,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic [1:0]        mem_size
);

    // port-level shadow of queue occupancy and pending barriers
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_n;
    logic          ub_pend;
    logic          dr_pend;
    logic          rst_q;
    logic          acc_b;
    logic          acc_u;
    logic          hs;

    assign acc_b = cpu_valid && !cpu_stall && cpu_bufferable;
    assign acc_u = cpu_valid && !cpu_stall && !cpu_bufferable;
    assign hs    = mem_valid && mem_ready;
    assign cnt_n = cnt + CW'(acc_b) - CW'(hs && (cnt != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            ub_pend <= 1'b0;
            dr_pend <= 1'b0;
            rst_q   <= 1'b1;
        end else begin
            rst_q <= 1'b0;
            cnt   <= cnt_n;
            if (acc_u)                        ub_pend <= 1'b1;
            else if (hs && cnt == '0)         ub_pend <= 1'b0;
            if (cpu_drain && !cpu_stall && cnt_n != '0) dr_pend <= 1'b1;
            else if (cnt_n == '0)             dr_pend <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!rst && rst_q) begin
            p_reset_idle_r1: assert (!cpu_stall && !mem_valid);
        end
    end

    p_valid_has_work_r3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (cnt != '0 || ub_pend));

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_size)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    p_full_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(DEPTH)) |-> cpu_stall);

    p_drain_stall_r5: assert property (@(posedge clk) disable iff (rst)
        dr_pend |-> cpu_stall);

    p_direct_stall_r7: assert property (@(posedge clk) disable iff (rst)
        ub_pend |-> cpu_stall);

endmodule

bind store_queue store_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_valid      (cpu_valid),
    .cpu_bufferable (cpu_bufferable),
    .cpu_drain      (cpu_drain),
    .cpu_stall      (cpu_stall),
    .mem_valid      (mem_valid),
    .mem_ready      (mem_ready),
    .mem_addr       (mem_addr),
    .mem_data       (mem_data),
    .mem_size       (mem_size)
);

// File: tb/store_queue_test.sv
module store_queue_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0;
    logic        cpu_bufferable = 1'b1;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_data = '0;
    logic [1:0]  cpu_size = '0;
    logic        cpu_drain = 1'b0;
    logic        cpu_stall;
    logic        mem_valid;
    logic        mem_ready;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic [1:0]  mem_size;

    logic auto = 1'b0;
    logic tog  = 1'b0;
    logic rdy  = 1'b0;
    int   checks = 0;
    int   fails  = 0;

    logic [31:0] log_a [0:31];
    logic [31:0] log_d [0:31];
    logic [1:0]  log_s [0:31];
    int          n = 0;

    // bufferable, size, address, data
    localparam logic [66:0] VEC [0:5] = '{
        {1'b1, 2'b10, 32'h0000_1000, 32'hDEAD_BEEF},
        {1'b1, 2'b00, 32'h0000_2003, 32'h0000_00A5},
        {1'b1, 2'b01, 32'h0000_3002, 32'h0000_1234},
        {1'b0, 2'b10, 32'h4000_0000, 32'hCAFE_F00D},
        {1'b1, 2'b10, 32'h0000_5000, 32'h0BAD_CAFE},
        {1'b1, 2'b00, 32'h0000_6001, 32'h0000_0077}
    };

    always #5 clk = ~clk;
    always @(negedge clk) tog <= ~tog;
    assign mem_ready = auto ? tog : rdy;

    store_queue uut (
        .clk            (clk),
        .rst            (rst),
        .cpu_valid      (cpu_valid),
        .cpu_bufferable (cpu_bufferable),
        .cpu_addr       (cpu_addr),
        .cpu_data       (cpu_data),
        .cpu_size       (cpu_size),
        .cpu_drain      (cpu_drain),
        .cpu_stall      (cpu_stall),
        .mem_valid      (mem_valid),
        .mem_ready      (mem_ready),
        .mem_addr       (mem_addr),
        .mem_data       (mem_data),
        .mem_size       (mem_size)
    );

    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready && n < 32) begin
            log_a[n] = mem_addr;
            log_d[n] = mem_data;
            log_s[n] = mem_size;
            n = n + 1;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic b, input logic [1:0] s, input logic [31:0] a, input logic [31:0] d);
        cpu_valid = 1'b1; cpu_bufferable = b; cpu_size = s; cpu_addr = a; cpu_data = d;
        tick();
        cpu_valid = 1'b0; cpu_bufferable = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int base;
        // R1 reset state
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 stall after reset", 32'(cpu_stall), 32'd0);
        check("R1 mem_valid after reset", 32'(mem_valid), 32'd0);

        // vector table: mixed sizes, one non-bufferable store, toggling ready
        base = n;
        auto = 1'b1;
        for (int i = 0; i < 6; i++) begin
            while (cpu_stall) tick();
            put(VEC[i][66], VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
        end
        while (cpu_stall) tick();
        cpu_drain = 1'b1; tick(); cpu_drain = 1'b0;
        while (cpu_stall) tick();
        repeat (4) tick();
        auto = 1'b0; rdy = 1'b0;
        tick();
        check("R3 table retire count", 32'(n - base), 32'd6);
        for (int i = 0; i < 6; i++) begin
            check("R3 table order addr", log_a[base + i], VEC[i][63:32]);
            check("R2 table data", log_d[base + i], VEC[i][31:0]);
            check("R2 table size", 32'(log_s[base + i]), 32'(VEC[i][65:64]));
        end

        // R2/R4 fill to full with memory not ready
        base = n;
        put(1'b1, 2'b10, 32'hA0, 32'h100);
        check("R2 head valid", 32'(mem_valid), 32'd1);
        check("R2 head addr", mem_addr, 32'hA0);
        check("R2 head size", 32'(mem_size), 32'd2);
        put(1'b1, 2'b00, 32'hA1, 32'h101);
        put(1'b1, 2'b01, 32'hA2, 32'h102);
        put(1'b1, 2'b10, 32'hA3, 32'h103);
        check("R4 stall when full", 32'(cpu_stall), 32'd1);
        cpu_valid = 1'b1; cpu_addr = 32'hA4; cpu_data = 32'h104; cpu_size = 2'b10;
        tick();
        check("R4 still stalled", 32'(cpu_stall), 32'd1);
        check("R3 head held while not ready", mem_addr, 32'hA0);
        rdy = 1'b1; tick(); rdy = 1'b0;
        check("R4 stall drops after retire", 32'(cpu_stall), 32'd0);
        check("R3 next head", mem_addr, 32'hA1);
        tick();
        cpu_valid = 1'b0;
        check("R4 full again after held store", 32'(cpu_stall), 32'd1);
        // R5 drain requested while stalled; taken when stall drops
        rdy = 1'b1; cpu_drain = 1'b1;
        tick();
        check("R5 stall low after retire", 32'(cpu_stall), 32'd0);
        tick();
        cpu_drain = 1'b0;
        check("R5 drain stall", 32'(cpu_stall), 32'd1);
        tick();
        check("R5 drain stall holds", 32'(cpu_stall), 32'd1);
        tick();
        rdy = 1'b0;
        check("R5 drain release", 32'(cpu_stall), 32'd0);
        check("R5 queue empty after drain", 32'(mem_valid), 32'd0);
        check("R3 fill retire count", 32'(n - base), 32'd5);
        for (int i = 0; i < 5; i++) begin
            check("R3 fill order", log_a[base + i], 32'hA0 + 32'(i));
        end

        // R5 drain held while memory stays busy
        put(1'b1, 2'b10, 32'hB0, 32'h200);
        put(1'b1, 2'b10, 32'hB1, 32'h201);
        cpu_drain = 1'b1; tick(); cpu_drain = 1'b0;
        check("R5 drain stall busy mem", 32'(cpu_stall), 32'd1);
        tick(); tick();
        check("R5 drain stall waits for memory", 32'(cpu_stall), 32'd1);
        rdy = 1'b1; tick();
        check("R5 one left", 32'(cpu_stall), 32'd1);
        tick(); rdy = 1'b0;
        check("R5 release after last", 32'(cpu_stall), 32'd0);

        // R6 drain taken as last entry retires, and drain on empty queue
        put(1'b1, 2'b00, 32'hC0, 32'h300);
        cpu_drain = 1'b1; rdy = 1'b1; tick(); cpu_drain = 1'b0; rdy = 1'b0;
        check("R6 no stall when last retires", 32'(cpu_stall), 32'd0);
        check("R6 queue empty", 32'(mem_valid), 32'd0);
        cpu_drain = 1'b1; tick(); cpu_drain = 1'b0;
        check("R6 no stall on empty", 32'(cpu_stall), 32'd0);

        // R5 store and drain on the same edge
        cpu_drain = 1'b1;
        put(1'b1, 2'b10, 32'hD0, 32'h400);
        cpu_drain = 1'b0;
        check("R5 same-edge drain stalls", 32'(cpu_stall), 32'd1);
        check("R5 same-edge store offered", mem_addr, 32'hD0);
        rdy = 1'b1; tick(); rdy = 1'b0;
        check("R5 same-edge release", 32'(cpu_stall), 32'd0);

        // R7 non-bufferable store behind a queued one
        base = n;
        put(1'b1, 2'b10, 32'hE0, 32'h500);
        put(1'b0, 2'b01, 32'hE1, 32'h501);
        check("R7 stall on direct store", 32'(cpu_stall), 32'd1);
        check("R7 queued store first", mem_addr, 32'hE0);
        tick();
        check("R7 still waiting", 32'(cpu_stall), 32'd1);
        rdy = 1'b1; tick(); rdy = 1'b0;
        check("R7 direct store offered", mem_addr, 32'hE1);
        check("R7 direct valid", 32'(mem_valid), 32'd1);
        check("R7 stall until ack", 32'(cpu_stall), 32'd1);
        tick();
        check("R7 direct held", mem_addr, 32'hE1);
        check("R7 stall held", 32'(cpu_stall), 32'd1);
        rdy = 1'b1; tick(); rdy = 1'b0;
        check("R7 release after ack", 32'(cpu_stall), 32'd0);
        check("R7 port idle", 32'(mem_valid), 32'd0);
        check("R7 order count", 32'(n - base), 32'd2);
        check("R7 order first", log_a[base], 32'hE0);
        check("R7 order second", log_a[base + 1], 32'hE1);
        put(1'b0, 2'b00, 32'hE2, 32'h502);
        check("R7 direct on empty offered", mem_addr, 32'hE2);
        check("R7 direct on empty stalls", 32'(cpu_stall), 32'd1);
        rdy = 1'b1; tick(); rdy = 1'b0;
        check("R7 direct on empty release", 32'(cpu_stall), 32'd0);

        // R8 reset with queued entries and pending drain
        put(1'b1, 2'b10, 32'hF0, 32'h600);
        put(1'b1, 2'b10, 32'hF1, 32'h601);
        cpu_drain = 1'b1; tick(); cpu_drain = 1'b0;
        check("R8 drain pending before reset", 32'(cpu_stall), 32'd1);
        rst = 1'b1; tick(); rst = 1'b0; tick();
        check("R8 stall cleared", 32'(cpu_stall), 32'd0);
        check("R8 queue cleared", 32'(mem_valid), 32'd0);
        put(1'b1, 2'b01, 32'hF8, 32'h608);
        check("R8 fresh head", mem_addr, 32'hF8);
        rdy = 1'b1; tick(); rdy = 1'b0;

        summary();
        $finish;
    end

endmodule